// File: doc/BRIEF.md
# Streaming Transmit Endpoint FIFO

This block is a circular byte buffer that feeds a USB IN endpoint (bulk, interrupt or isochronous) whose packets can be longer than the buffer. Software pushes bytes through a write port while the endpoint controller pulls them onto the bus through a read port. Storage is reused as it drains, so a packet of any length can stream through a small buffer as long as software keeps up.

The controller sees the oldest stored byte on `rd_data` at all times and takes it by pulsing `rd_en`. With each request it also gives a last-byte indication. A request against an empty buffer is a shortfall (underrun) only when that indication is low. The buffer reports:
- its fill level and the matching free-byte count;
- a low-level warning against a threshold that can be programmed;
- sticky overrun and underrun flags, which are cleared by a dedicated input.

A flush input empties the buffer at once.

Top module: `stream_tx_fifo`

## Requirements
- R1: After reset, `level` is 0, `free_cnt` equals DEPTH, `overrun` and `underrun` are 0, and `warn` is 1.
- R2: Bytes leave in the order they were written. `rd_data` shows the oldest stored byte combinationally, and each accepted read advances to the next byte.
- R3: The read and write positions wrap to zero after position DEPTH-1. Order is kept across any number of wraps, including when DEPTH is not a power of two (default DEPTH is 12).
- R4: One clock edge after any change, `level` equals the number of stored bytes, and `free_cnt` equals DEPTH minus `level`.
- R5: A write on a full buffer with no read in the same cycle is dropped. Contents and level are left unchanged, and `overrun` is set.
- R6: A read request on an empty buffer does not move the read position. It sets `underrun` only when `rd_last` is 0. When `rd_last` is 1, `underrun` stays unchanged.
- R7: `warn` is 1 exactly when `level` is less than or equal to `warn_thr`.
- R8: `flush` returns both positions to zero, so `level` is 0 after the edge. A write or read in the same cycle is ignored, and neither one sets a flag.
- R9: `overrun` and `underrun` stay set until a cycle with `clr_err` high. If a new event occurs in the same cycle as the clear, the flag stays set.
- R10: A read and a write in the same cycle are both applied and `level` is unchanged. On a full buffer, the read frees room for that write, so `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the buffer (positions to zero) |
| clr_err | input | 1 | Clear sticky overrun/underrun flags |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | DW | Byte to write |
| rd_en | input | 1 | Controller read request |
| rd_last | input | 1 | Current request belongs to the final byte of the packet |
| rd_data | output | DW | Oldest stored byte |
| warn_thr | input | LW | Low-level warning threshold |
| level | output | LW | Bytes stored |
| free_cnt | output | LW | Empty byte slots |
| warn | output | 1 | Level at or below threshold |
| overrun | output | 1 | Sticky: write dropped on full |
| underrun | output | 1 | Sticky: read on empty without last flag |

## Verification
On every cycle, the assertions check the following:
- level plus free count always equals DEPTH;
- flush always leaves the buffer empty;
- a blocked write or a non-last read on empty raises its sticky flag, and the flag then holds until cleared;
- a simultaneous accepted read and write never changes the level.

Only the bench's scenarios can show that data comes out byte for byte in write order across several wraps of a non-power-of-two buffer. The same holds for:
- a dropped write leaving no trace in the stored contents;
- a flush discarding stale bytes so that the next byte read is a newly written one.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

  // Next slot index with wrap at depth-1.
  function automatic int unsigned slot_after(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // Stored bytes from two wrap-tagged positions.
  function automatic int unsigned fill_of(int unsigned widx, int unsigned ridx,
                                          logic wlap, logic rlap, int unsigned depth);
    return (wlap == rlap) ? (widx - ridx) : (depth - ridx + widx);
  endfunction

endpackage

// File: rtl/tfifo_ptr.sv
module tfifo_ptr #(
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        zero,
  input  logic        step,
  output logic [AW:0] pos
);
  import tfifo_pkg::*;

  logic [AW-1:0] idx_nx;
  logic          lap_nx;

  always_comb begin
    idx_nx = AW'(slot_after(32'(pos[AW-1:0]), DEPTH));
    lap_nx = (idx_nx == '0) ? ~pos[AW] : pos[AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (zero) pos <= '0;
    else if (step) pos <= {lap_nx, idx_nx};
  end
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/tfifo_stat.sv
module tfifo_stat #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int LW    = 4
) (
  input  logic [AW:0]   wpos,
  input  logic [AW:0]   rpos,
  input  logic [LW-1:0] thr,
  output logic [LW-1:0] fill,
  output logic [LW-1:0] room,
  output logic          low,
  output logic          is_empty,
  output logic          is_full
);
  import tfifo_pkg::*;

  always_comb begin
    fill = LW'(fill_of(32'(wpos[AW-1:0]), 32'(rpos[AW-1:0]), wpos[AW], rpos[AW], DEPTH));
    room = LW'(DEPTH) - fill;
    low  = (fill <= thr);
  end

  assign is_empty = (wpos == rpos);
  assign is_full  = (wpos[AW-1:0] == rpos[AW-1:0]) && (wpos[AW] != rpos[AW]);
endmodule

// File: rtl/stream_tx_fifo.sv
module stream_tx_fifo #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          clr_err,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_last,
  output logic [DW-1:0] rd_data,
  input  logic [LW-1:0] warn_thr,
  output logic [LW-1:0] level,
  output logic [LW-1:0] free_cnt,
  output logic          warn,
  output logic          overrun,
  output logic          underrun
);
  logic [AW:0] wpos, rpos;
  logic        is_empty, is_full;

  // Named internal events
  logic rd_acc, wr_acc, ovr_evt, udr_evt;

  assign rd_acc  = rd_en && !is_empty && !flush;
  assign wr_acc  = wr_en && !flush && (!is_full || rd_acc);
  assign ovr_evt = wr_en && !flush && !wr_acc;
  assign udr_evt = rd_en && !flush && is_empty && !rd_last;

  tfifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .zero(flush), .step(wr_acc), .pos(wpos));

  tfifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .zero(flush), .step(rd_acc), .pos(rpos));

  tfifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(wr_acc), .waddr(wpos[AW-1:0]), .wdata(wr_data),
    .raddr(rpos[AW-1:0]), .rdata(rd_data));

  tfifo_stat #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_stat (
    .wpos(wpos), .rpos(rpos), .thr(warn_thr), .fill(level), .room(free_cnt),
    .low(warn), .is_empty(is_empty), .is_full(is_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      overrun  <= ovr_evt | (overrun  & ~clr_err);
      underrun <= udr_evt | (underrun & ~clr_err);
    end
  end
endmodule

// File: rtl/tfifo_chk.sv
module tfifo_chk #(
  parameter int DEPTH = 12,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          clr_err,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rd_last,
  input logic [LW-1:0] warn_thr,
  input logic [LW-1:0] level,
  input logic [LW-1:0] free_cnt,
  input logic          warn,
  input logic          overrun,
  input logic          underrun,
  input logic          wr_acc,
  input logic          rd_acc
);
  // R4
  level_free_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(level) + 32'(free_cnt)) == DEPTH);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  // R7
  warn_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn == (level <= warn_thr));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !flush && 32'(level) == DEPTH) |=> (32'(level) == DEPTH) && overrun);

  // R6
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !flush && level == '0) |=> (level == '0));

  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_last && !flush && level == '0) |=> underrun);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_err) |=> overrun);

  // R9
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_err) |=> underrun);

  // R10
  both_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc && !flush) |=> (level == $past(level)));
endmodule

bind stream_tx_fifo tfifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .clr_err(clr_err),
  .wr_en(wr_en), .rd_en(rd_en), .rd_last(rd_last), .warn_thr(warn_thr),
  .level(level), .free_cnt(free_cnt), .warn(warn), .overrun(overrun),
  .underrun(underrun), .wr_acc(wr_acc), .rd_acc(rd_acc));

// File: tb/sim_stream_tx_fifo.sv
module sim_stream_tx_fifo;
  localparam int D  = 12;
  localparam int DW = 8;
  localparam int LW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 0, clr_err = 0, wr_en = 0, rd_en = 0, rd_last = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] warn_thr = LW'(2);
  logic [LW-1:0] level, free_cnt;
  logic warn, overrun, underrun;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  bit e_ovr = 0, e_udr = 0;

  always #2 clk = ~clk;

  stream_tx_fifo #(.DEPTH(D), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .clr_err(clr_err),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_last(rd_last),
    .rd_data(rd_data), .warn_thr(warn_thr), .level(level), .free_cnt(free_cnt),
    .warn(warn), .overrun(overrun), .underrun(underrun));

  task automatic check(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus with the bench's own model update.
  task automatic cyc(bit w, logic [DW-1:0] wd, bit r, bit last, bit fl, bit clr);
    bit acc_r, acc_w;
    wr_en = w; wr_data = wd; rd_en = r; rd_last = last; flush = fl; clr_err = clr;
    acc_r = r && !fl && q.size() > 0;
    acc_w = w && !fl && (q.size() < D || acc_r);
    #1;
    if (acc_r) check("R2", "rd_data", int'(rd_data), int'(q[0]));
    @(posedge clk); #1;
    if (fl) q.delete();
    else begin
      if (acc_r) void'(q.pop_front());
      if (acc_w) q.push_back(wd);
    end
    e_ovr = (w && !fl && !acc_w) || (e_ovr && !clr);
    e_udr = (r && !fl && !acc_r && !last) || (e_udr && !clr);
    wr_en = 0; rd_en = 0; rd_last = 0; flush = 0; clr_err = 0;
  endtask

  task automatic chk_level(string req);
    check(req, "level", int'(level), q.size());
    check(req, "free_cnt", int'(free_cnt), D - q.size());
  endtask

  task automatic t_reset;
    check("R1", "level", int'(level), 0);
    check("R1", "free_cnt", int'(free_cnt), D);
    check("R1", "overrun", int'(overrun), 0);
    check("R1", "underrun", int'(underrun), 0);
    check("R1", "warn", int'(warn), 1);
  endtask

  task automatic t_order;
    for (int i = 0; i < 5; i++) cyc(1, DW'(8'h30 + i), 0, 0, 0, 0);
    chk_level("R4");
    for (int i = 0; i < 5; i++) begin
      check("R2", "head", int'(rd_data), 8'h30 + i);
      cyc(0, 0, 1, i == 4, 0, 0);
    end
    chk_level("R4");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 40; i++) begin
      cyc((i % 3) != 2, DW'(8'h80 + i), (i % 2) == 1 && q.size() > 0, 0, 0, 0);
      chk_level("R3");
    end
    while (q.size() > 0) cyc(0, 0, 1, q.size() == 1, 0, 0);
    chk_level("R3");
    check("R3", "underrun", int'(underrun), 0);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < D; i++) cyc(1, DW'(8'h10 + i), 0, 0, 0, 0);
    check("R5", "level full", int'(level), D);
    check("R5", "overrun before", int'(overrun), 0);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    check("R5", "level after drop", int'(level), D);
    check("R5", "overrun", int'(overrun), 1);
    for (int i = 0; i < D; i++) begin
      check("R5", "content", int'(rd_data), 8'h10 + i);
      cyc(0, 0, 1, 0, 0, 0);
    end
    chk_level("R5");
  endtask

  task automatic t_clear;
    cyc(0, 0, 0, 0, 0, 1);
    check("R9", "overrun cleared", int'(overrun), 0);
    cyc(0, 0, 1, 1, 0, 0);
    check("R6", "underrun with last", int'(underrun), 0);
    check("R6", "level", int'(level), 0);
    cyc(0, 0, 1, 0, 0, 0);
    check("R6", "underrun without last", int'(underrun), 1);
    check("R6", "level", int'(level), 0);
    repeat (2) cyc(0, 0, 0, 0, 0, 0);
    check("R9", "underrun sticky", int'(underrun), 1);
    cyc(0, 0, 1, 0, 0, 1);
    check("R9", "event beats clear", int'(underrun), 1);
    cyc(0, 0, 0, 0, 0, 1);
    check("R9", "underrun cleared", int'(underrun), 0);
    check("R9", "model", int'(e_udr), 0);
  endtask

  task automatic t_simul;
    for (int i = 0; i < 3; i++) cyc(1, DW'(8'h50 + i), 0, 0, 0, 0);
    cyc(1, 8'h60, 1, 0, 0, 0);
    check("R10", "level steady", int'(level), 3);
    while (q.size() < D) cyc(1, DW'(8'h70 + q.size()), 0, 0, 0, 0);
    cyc(1, 8'h99, 1, 0, 0, 0);
    check("R10", "full level steady", int'(level), D);
    check("R10", "no overrun", int'(overrun), 0);
    while (q.size() > 0) cyc(0, 0, 1, 0, 0, 0);
    cyc(1, 8'hA5, 1, 0, 0, 0);
    check("R10", "empty write+read level", int'(level), 1);
    check("R6", "empty read flags underrun", int'(underrun), 1);
    check("R2", "head", int'(rd_data), 8'hA5);
    cyc(0, 0, 1, 1, 0, 1);
  endtask

  task automatic t_warn;
    warn_thr = LW'(4);
    for (int i = 0; i < 5; i++) cyc(1, DW'(i), 0, 0, 0, 0);
    check("R7", "warn at 5 thr 4", int'(warn), 0);
    cyc(0, 0, 1, 0, 0, 0);
    check("R7", "warn at 4 thr 4", int'(warn), 1);
    warn_thr = LW'(0);
    #1;
    check("R7", "warn at 4 thr 0", int'(warn), 0);
    warn_thr = LW'(2);
  endtask

  task automatic t_flush;
    cyc(1, 8'h77, 1, 0, 1, 0);
    check("R8", "level", int'(level), 0);
    check("R8", "free_cnt", int'(free_cnt), D);
    check("R8", "no overrun", int'(overrun), 0);
    check("R8", "no underrun", int'(underrun), 0);
    cyc(1, 8'hC3, 0, 0, 0, 0);
    check("R8", "fresh byte", int'(rd_data), 8'hC3);
    cyc(0, 0, 1, 1, 0, 0);
    chk_level("R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_order();
    t_wrap();
    t_overrun();
    t_clear();
    t_simul();
    t_warn();
    t_flush();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule